// File: doc/BRIEF.md
# Clock Synthesizer Output Back End

This block is the digital back end of a frequency synthesizer. It takes a fast source clock and divides it twice. An output divider produces the main output at one of four power-of-two ratios. A 9-bit loop counter produces a terminal-count pulse every M source cycles. An enable input gates the main output so that it never shows a shortened high phase. A test pin shows one of eight internal nodes, chosen by a 3-bit test code.

One test code selects bypass mode. In that mode the dividers count rising edges of the serial configuration clock instead of the oscillator clock. The main output then follows the output divider, and the test pin follows the loop counter. Board-level debug can use this mode to step the clock tree by hand.

The whole block runs on one system clock `clk`. The oscillator and the crystal are presented as single-cycle strobes (`vco_tick`, `xtal_tick`). Each `vco_tick` marks one edge of the source clock. The serial clock is a level, and the block finds its rising edges by comparing it with its value in the previous `clk` cycle.

Top module: `clkgen_backend`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `fout` is 0 and the loop-counter pulse is 0. The first source tick after reset toggles the output divider and fires the loop counter.
- R2: In normal mode, the internal divider level toggles on every 2^n-th source tick, where n is the code on `n_sel` (0→1, 1→2, 2→4, 3→8). `fout` is that level ANDed with the latched enable, and it changes one `clk` cycle after the tick.
- R3: A new `n_sel` value is used only when the divider reaches its next terminal count. A half-period that has already started keeps its old length.
- R4: The loop counter raises a one-cycle pulse on the tick that reaches terminal count, then reloads M-1. The pulse repeats every M ticks, and M=0 counts 512 ticks.
- R5: Test code map for `test_out`: 000 gives `shift_out`, 001 gives 1, 100 gives `fout` and 101 gives 0.
- R6: Test code 110 selects bypass. Ticks are then the rising edges of `ser_clk` seen on `clk`, and each half-period is max(2^n/2, 1) edges. `test_out` carries the loop-counter pulse.
- R7: `oe` is sampled only when the divider level rises. A sampled 1 lets the whole high phase through; a sampled 0 holds `fout` low until a later rising boundary. Every high phase of `fout` is full length.
- R8: Test code 010 gives the reference clock. This clock toggles on every 8th `xtal_tick`, so one period spans 16 crystal strobes. Test code 011 gives the loop-counter pulse.
- R9: Test code 111 gives the main divider output divided by 4. This output toggles on every second rising step of the internal divider level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_tick | input | 1 | One strobe per edge of the oscillator clock |
| xtal_tick | input | 1 | One strobe per crystal cycle |
| ser_clk | input | 1 | Serial configuration clock level |
| shift_out | input | 1 | Configuration shift register serial output |
| n_sel | input | 2 | Output divider code |
| m_val | input | 9 | Loop counter modulus |
| t_sel | input | 3 | Test pin selector |
| oe | input | 1 | Output enable, active high |
| fout | output | 1 | Gated main output |
| test_out | output | 1 | Selected test node |

## Verification
Several properties are checked on every cycle. The output and the loop-counter pulse change only in the cycle after a tick. The reference clock changes only after a crystal strobe. The latched enable changes only on a rising divider boundary. In bypass mode, output changes follow a sampled serial rising edge. Exact periods, the moment a new divide code takes effect, the 512-count for M=0, the divide-by-4 test node and the full test map are shown only by the bench's scenarios, which compare every cycle with a model built from the requirements.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [2:0] {
        TS_SHIFT  = 3'b000,
        TS_HIGH   = 3'b001,
        TS_REF    = 3'b010,
        TS_MCNT   = 3'b011,
        TS_FOUT   = 3'b100,
        TS_LOW    = 3'b101,
        TS_BYPASS = 3'b110,
        TS_FOUT_Q = 3'b111
    } test_sel_e;

    typedef struct packed {
        logic lvl;
        logic en;
    } div_state_t;

    // Half-period length in ticks; bypass ticks are whole serial cycles.
    function automatic int half_ticks(int code, logic byp);
        if (byp) return (code == 0) ? 1 : (1 << (code - 1));
        return 1 << code;
    endfunction

endpackage

// File: rtl/clkgen_ref_div.sv
module clkgen_ref_div #(
    parameter int REF_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic xtal_tick,
    output logic ref_lvl
);
    localparam int HALF  = REF_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ref_lvl <= 1'b0;
        end else if (xtal_tick) begin
            if (cnt == CNT_W'(HALF - 1)) begin
                cnt     <= '0;
                ref_lvl <= ~ref_lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkgen_loop_ctr.sv
module clkgen_loop_ctr #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [M_W-1:0] m_val,
    output logic           m_tc
);
    logic [M_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            m_tc <= 1'b0;
        end else begin
            m_tc <= 1'b0;
            if (tick) begin
                if (cnt == '0) begin
                    // M of zero wraps to all ones: the longest count
                    cnt  <= m_val - 1'b1;
                    m_tc <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clkgen_out_div.sv
module clkgen_out_div
    import clkgen_pkg::*;
#(
    parameter int N_SEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               bypass,
    input  logic [N_SEL_W-1:0] n_sel,
    input  logic               oe,
    output logic               div_lvl,
    output logic               div_en,
    output logic               quarter
);
    localparam int MAX_HALF = 1 << ((1 << N_SEL_W) - 1);
    localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    div_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic [1:0]       qcnt;

    assign reload = CNT_W'(half_ticks(int'(n_sel), bypass) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            st   <= '0;
            qcnt <= '0;
        end else if (tick) begin
            if (cnt == '0) begin
                cnt <= reload;
                if (!st.lvl) begin
                    st.lvl <= 1'b1;
                    st.en  <= oe;
                    qcnt   <= qcnt + 1'b1;
                end else begin
                    st.lvl <= 1'b0;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign div_lvl = st.lvl;
    assign div_en  = st.en;
    assign quarter = qcnt[1];
endmodule

// File: rtl/clkgen_backend.sv
module clkgen_backend
    import clkgen_pkg::*;
#(
    parameter int M_W     = 9,
    parameter int N_SEL_W = 2,
    parameter int REF_DIV = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vco_tick,
    input  logic               xtal_tick,
    input  logic               ser_clk,
    input  logic               shift_out,
    input  logic [N_SEL_W-1:0] n_sel,
    input  logic [M_W-1:0]     m_val,
    input  logic [2:0]         t_sel,
    input  logic               oe,
    output logic               fout,
    output logic               test_out
);
    logic ser_q;
    logic bypass;
    logic tick;
    logic div_lvl;
    logic div_en;
    logic quarter;
    logic m_tc;
    logic ref_lvl;
    test_sel_e tsel;

    always_ff @(posedge clk) ser_q <= ser_clk;

    assign tsel   = test_sel_e'(t_sel);
    assign bypass = (tsel == TS_BYPASS);
    assign tick   = bypass ? (ser_clk & ~ser_q) : vco_tick;

    clkgen_ref_div #(.REF_DIV(REF_DIV)) u_ref (
        .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .ref_lvl(ref_lvl)
    );

    clkgen_loop_ctr #(.M_W(M_W)) u_loop (
        .clk(clk), .rst(rst), .tick(tick), .m_val(m_val), .m_tc(m_tc)
    );

    clkgen_out_div #(.N_SEL_W(N_SEL_W)) u_odiv (
        .clk(clk), .rst(rst), .tick(tick), .bypass(bypass), .n_sel(n_sel),
        .oe(oe), .div_lvl(div_lvl), .div_en(div_en), .quarter(quarter)
    );

    assign fout = div_lvl & div_en;

    always_comb begin
        case (tsel)
            TS_SHIFT:  test_out = shift_out;
            TS_HIGH:   test_out = 1'b1;
            TS_REF:    test_out = ref_lvl;
            TS_MCNT:   test_out = m_tc;
            TS_FOUT:   test_out = fout;
            TS_LOW:    test_out = 1'b0;
            TS_BYPASS: test_out = m_tc;
            default:   test_out = quarter;
        endcase
    end
endmodule

// File: rtl/clkgen_backend_chk.sv
module clkgen_backend_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       xtal_tick,
    input logic       ser_clk,
    input logic [2:0] t_sel,
    input logic       fout,
    input logic       m_tc,
    input logic       div_lvl,
    input logic       div_en,
    input logic       ref_lvl
);
    p_fout_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (fout != $past(fout)) |-> $past(tick));

    p_pulse_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        m_tc |-> $past(tick));

    p_enable_at_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (div_en != $past(div_en)) |-> (div_lvl && !$past(div_lvl)));

    p_ref_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_lvl != $past(ref_lvl)) |-> $past(xtal_tick));

    p_bypass_edge_r6: assert property (@(posedge clk) disable iff (rst)
        ((fout != $past(fout)) && ($past(t_sel) == 3'b110))
            |-> ($past(ser_clk) && !$past(ser_clk, 2)));
endmodule

bind clkgen_backend clkgen_backend_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .xtal_tick(xtal_tick),
    .ser_clk(ser_clk), .t_sel(t_sel), .fout(fout), .m_tc(m_tc),
    .div_lvl(div_lvl), .div_en(div_en), .ref_lvl(ref_lvl)
);

// File: tb/clkgen_backend_tb.sv
module clkgen_backend_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vco_tick = 1'b0, xtal_tick = 1'b0, ser_clk = 1'b0;
    logic       shift_out = 1'b0, oe = 1'b1;
    logic [1:0] n_sel = 2'd0;
    logic [8:0] m_val = 9'd3;
    logic [2:0] t_sel = 3'd0;
    logic       fout, test_out;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clkgen_backend u_dut (
        .clk(clk), .rst(rst), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
        .ser_clk(ser_clk), .shift_out(shift_out), .n_sel(n_sel),
        .m_val(m_val), .t_sel(t_sel), .oe(oe), .fout(fout), .test_out(test_out)
    );

    // Model state built from the requirements
    int   mc, nc, rc, q2;
    logic lvl, en, rl, mtc, sprev = 1'b0;

    function automatic int half_len(int n, bit byp);
        if (byp) return (n == 0) ? 1 : (1 << (n - 1));
        return 1 << n;
    endfunction

    always @(posedge clk) begin
        bit byp, tk;
        byp = (t_sel == 3'b110);
        tk  = byp ? (ser_clk && !sprev) : vco_tick;
        sprev = ser_clk;
        if (rst) begin
            mc = 0; nc = 0; rc = 0; q2 = 0;
            lvl = 0; en = 0; rl = 0; mtc = 0;
        end else begin
            mtc = 0;
            if (tk) begin
                if (mc == 0) begin
                    mc = (m_val == 0) ? 511 : int'(m_val) - 1;
                    mtc = 1;
                end else mc = mc - 1;
                if (nc == 0) begin
                    nc = half_len(int'(n_sel), byp) - 1;
                    if (!lvl) begin lvl = 1; en = oe; q2 = (q2 + 1) % 4; end
                    else lvl = 0;
                end else nc = nc - 1;
            end
            if (xtal_tick) begin
                if (rc == 7) begin rc = 0; rl = !rl; end else rc = rc + 1;
            end
        end
    end

    function automatic logic exp_test();
        case (t_sel)
            3'd0: return shift_out;
            3'd1: return 1'b1;
            3'd2: return rl;
            3'd3: return mtc;
            3'd4: return lvl & en;
            3'd5: return 1'b0;
            3'd6: return mtc;
            default: return q2[1];
        endcase
    endfunction

    function automatic string test_tag();
        case (t_sel)
            3'd2: return "R8";
            3'd3: return "R4 R8";
            3'd6: return "R6";
            3'd7: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle_check();
        @(negedge clk);
        chk((t_sel == 3'b110) ? "R6" : "R2 R3 R7", fout, lvl & en);
        chk(test_tag(), test_out, exp_test());
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        // R1: reset state
        t_sel = 3'd3; vco_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", fout, 1'b0);
        chk("R1", test_out, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", test_out, 1'b1);          // first tick fires counter
        vco_tick = 1'b0;
        @(negedge clk);
        chk("R1", fout, 1'b1);              // first tick raised level, oe=1

        // R4: M=0 counts 512 ticks, seen on the counter test node
        m_val = 9'd0; vco_tick = 1'b1;
        begin
            int gap = 0;
            bit seen = 0;
            for (int i = 0; i < 1100; i++) begin
                cycle_check();
                if (test_out) begin
                    if (seen) begin
                        chk("R4", gap == 512, 1'b1);
                        if (gap != 512) $display("FAIL R4: actual gap %0d expected 512", gap);
                    end
                    seen = 1; gap = 1;
                end else gap++;
            end
        end

        // R6: bypass with serial clock toggling every clk cycle
        t_sel = 3'd6; n_sel = 2'd0; m_val = 9'd2; vco_tick = 1'b0;
        for (int i = 0; i < 60; i++) begin
            ser_clk = ~ser_clk;
            cycle_check();
        end

        // R3 R7: directed divide-code change and enable drop
        t_sel = 3'd4; vco_tick = 1'b1; n_sel = 2'd2;
        for (int i = 0; i < 40; i++) begin
            if (i == 13) n_sel = 2'd0;
            if (i == 21) oe = 1'b0;
            if (i == 31) oe = 1'b1;
            cycle_check();
        end

        // Random phases with directed mid-phase changes
        for (int ph = 0; ph < 80; ph++) begin
            int tprob, sprob;
            n_sel = 2'($urandom_range(0, 3));
            m_val = ($urandom_range(0, 9) == 0) ? 9'd0 : 9'($urandom_range(1, 14));
            t_sel = 3'($urandom_range(0, 7));
            oe    = ($urandom_range(0, 3) != 0);
            tprob = $urandom_range(1, 4);
            sprob = $urandom_range(1, 3);
            for (int i = 0; i < 250; i++) begin
                vco_tick  = ($urandom_range(1, tprob) == 1);
                xtal_tick = ($urandom_range(0, 1) == 1);
                if ($urandom_range(1, sprob) == 1) ser_clk = ~ser_clk;
                shift_out = 1'($urandom_range(0, 1));
                if (i == 125) begin
                    n_sel = 2'($urandom_range(0, 3));
                    oe    = ~oe;
                end
                cycle_check();
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule